// File: doc/BRIEF.md
# Message-Signalled Interrupt File with Claim

This block is the per-hart interrupt file that collects message-signalled interrupts. Devices post an interrupt identity by writing a 32-bit word to one of two set-pending offsets on a small bus slave. One offset takes the word as is. The other takes it byte-reversed, so that big-endian producers can use the same file. Each accepted identity raises one pending bit. Pending and enable bits are packed into 64-bit words.

A local register port reaches the file's state through a select value. Every access is a masked read-modify-write that returns the old contents. The selectable state is:

- a delivery-enable bit;
- a priority threshold;
- the pending words;
- the enable words;
- a top-interrupt register.

The top-interrupt register reports the lowest-numbered interrupt that is both pending and enabled and lies below the threshold. A write to it claims that interrupt. The external-interrupt request line is derived combinationally from the same stored state as the top-interrupt value. As a result, a message that arrives during a claim can never be lost between the two.

Top module: `msi_intr_file`

## Requirements
- R1: After reset, delivery, threshold, and every pending and enable bit are zero. Reads of these return 0, the top-interrupt value is 0 and `eintr` is low.
- R2: A valid 4-byte write to MMIO offset 0x000 with data N (1 <= N < NUM_IDS) sets pending bit N. Bit N sits in pending word N/64 at bit N%64.
- R3: A valid 4-byte write to MMIO offset 0x004 byte-reverses the data before use. Data 0x03000000 therefore sets pending bit 3.
- R4: An identity of 0 is ignored without any flag. An identity at or above NUM_IDS raises `mmio_reject` in that cycle and changes nothing.
- R5: An MMIO access whose size is not 4 bytes, or whose address is not 4-byte aligned, raises `mmio_err` and has no effect. MMIO reads have no effect and raise no flag.
- R6: A register access with select S returns the old value V in the same cycle with status 0. At the next clock edge the register becomes (V & ~mask) | (data & mask).
- R7: The delivery register is select 0x070 and only its bit 0 is writable. The threshold register is select 0x072 and is ID_W bits wide; upper write bits are discarded.
- R8: Pending word k is select 0x080+2k and enable word k is select 0x0C0+2k. Bit 0 of pending word 0 and bit 0 of enable word 0 always read as 0 and cannot be written.
- R9: Status is 1 ("invalid") for an odd pending/enable select, or for one whose word index (select offset / 2) is at or beyond the implemented word count. Status is 2 ("not found") for any other unknown select. In both cases the read data is 0 and nothing changes.
- R10: The top-interrupt register is select 0x15C. It reads (I << 16) | I, where I is the lowest identity >= 1 that is pending and enabled and below the limit. The limit is the threshold when the threshold is nonzero and at most NUM_IDS; otherwise the limit is NUM_IDS. When there is no such identity it reads 0.
- R11: A write to select 0x15C with a nonzero mask clears the pending bit of the current top identity. The written data is ignored. A zero mask clears nothing.
- R12: `eintr` is high exactly when delivery is 1 and the top-interrupt value is nonzero. It follows the state updated at the previous clock edge.
- R13: If a set-pending message and a claim occur in the same cycle, both take effect. When both name the same identity, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmio_valid | input | 1 | MMIO access strobe |
| mmio_write | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | ADDR_W | Byte offset inside the MMIO page |
| mmio_size | input | 3 | Access size in bytes |
| mmio_wdata | input | 32 | Write data (interrupt identity) |
| mmio_err | output | 1 | Unsupported size or misaligned access |
| mmio_reject | output | 1 | Identity out of range |
| reg_valid | input | 1 | Register access strobe |
| reg_sel | input | 12 | Register select |
| reg_wdata | input | 64 | Write data |
| reg_wmask | input | 64 | Write mask (0 = read only) |
| reg_rdata | output | 64 | Old value of the selected register |
| reg_status | output | 2 | 0 ok, 1 invalid, 2 not found |
| eintr | output | 1 | External interrupt request |

## Verification
The bound checker checks the following properties on every cycle:
- the shape of each response: error flags for bad MMIO sizes, the invalid and not-found codes, zero high bits on delivery and threshold reads, and the read-only bit 0 of word 0;
- the duplicated-field format of the top value;
- that `eintr` is low whenever a read shows no top interrupt or delivery off.

Some behaviour involves state built up over several accesses, and only the bench scenarios can show it:
- which identity wins the priority search;
- how the threshold limit behaves at and above the interrupt count;
- that a claim removes exactly the claimed bit;
- the ordering when a claim and a message collide in one cycle.

// File: rtl/msi_intr_file.sv
module msi_intr_file #(
  parameter int ID_W      = 11,
  parameter int NUM_IDS   = 128,
  parameter int ADDR_W    = 12,
  parameter int TOP_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmio_valid,
  input  logic              mmio_write,
  input  logic [ADDR_W-1:0] mmio_addr,
  input  logic [2:0]        mmio_size,
  input  logic [31:0]       mmio_wdata,
  output logic              mmio_err,
  output logic              mmio_reject,
  input  logic              reg_valid,
  input  logic [11:0]       reg_sel,
  input  logic [63:0]       reg_wdata,
  input  logic [63:0]       reg_wmask,
  output logic [63:0]       reg_rdata,
  output logic [1:0]        reg_status,
  output logic              eintr
);
  localparam int NGRP  = (NUM_IDS + 63) / 64;
  localparam int NBITS = NGRP * 64;
  localparam int IW    = $clog2(NBITS);
  localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [11:0] SEL_DELIV = 12'h070;
  localparam logic [11:0] SEL_THR   = 12'h072;
  localparam logic [11:0] SEL_PEND  = 12'h080;
  localparam logic [11:0] SEL_EN    = 12'h0C0;
  localparam logic [11:0] SEL_TOP   = 12'h15C;
  localparam logic [63:0] THR_MASK  = (64'd1 << ID_W) - 64'd1;
  localparam logic [ADDR_W-1:0] OFS_LE = '0;
  localparam logic [ADDR_W-1:0] OFS_BE = ADDR_W'(4);
  localparam logic [1:0] ST_OK = 2'd0, ST_BAD = 2'd1, ST_NONE = 2'd2;

  logic              deliv;
  logic [ID_W-1:0]   thr;
  logic [NBITS-1:0]  pend, en, pend_n, en_n;

  logic        acc_ok, is_le, is_be, id_big, set_hit;
  logic [31:0] swapped, set_id;

  assign acc_ok  = (mmio_size == 3'd4) && (mmio_addr[1:0] == 2'b00);
  assign is_le   = mmio_valid && mmio_write && acc_ok && (mmio_addr == OFS_LE);
  assign is_be   = mmio_valid && mmio_write && acc_ok && (mmio_addr == OFS_BE);
  assign swapped = {mmio_wdata[7:0], mmio_wdata[15:8], mmio_wdata[23:16], mmio_wdata[31:24]};
  assign set_id  = is_be ? swapped : mmio_wdata;
  assign id_big  = set_id >= 32'(NUM_IDS);
  assign set_hit = (is_le || is_be) && !id_big && (set_id != 32'd0);
  assign mmio_err    = mmio_valid && !acc_ok;
  assign mmio_reject = (is_le || is_be) && id_big;

  logic [ID_W-1:0] top_id;
  logic [63:0]     top_val;
  int              lim;

  always_comb begin
    lim    = (thr != '0 && int'(thr) <= NUM_IDS) ? int'(thr) : NUM_IDS;
    top_id = '0;
    for (int i = NBITS - 1; i >= 1; i--)
      if (pend[i] && en[i] && i < lim) top_id = ID_W'(i);
  end
  assign top_val = (64'(top_id) << TOP_SHIFT) | 64'(top_id);

  logic          in_pend, in_en, word_ok, wr_ok, claim;
  logic [5:0]    num;
  logic [4:0]    grp;
  logic [GW-1:0] gi;
  logic [63:0]   old_v, eff_m, new_v;
  logic [1:0]    st;

  assign in_pend = (reg_sel >= SEL_PEND) && (reg_sel < SEL_EN);
  assign in_en   = (reg_sel >= SEL_EN) && (reg_sel < SEL_EN + 12'd64);
  assign num     = reg_sel[5:0];
  assign grp     = num[5:1];
  assign gi      = GW'(grp);
  assign word_ok = !num[0] && (32'(grp) < 32'(NGRP));

  always_comb begin
    old_v = '0;
    eff_m = '0;
    st    = ST_NONE;
    if (reg_sel == SEL_DELIV) begin
      st = ST_OK; old_v = {63'd0, deliv}; eff_m = reg_wmask & 64'd1;
    end else if (reg_sel == SEL_THR) begin
      st = ST_OK; old_v = 64'(thr); eff_m = reg_wmask & THR_MASK;
    end else if (reg_sel == SEL_TOP) begin
      st = ST_OK; old_v = top_val;
    end else if (in_pend || in_en) begin
      if (word_ok) begin
        st    = ST_OK;
        old_v = in_pend ? pend[gi*64 +: 64] : en[gi*64 +: 64];
        eff_m = reg_wmask & ((num == 6'd0) ? ~64'd1 : ~64'd0);
      end else begin
        st = ST_BAD;
      end
    end
    if (!reg_valid) begin
      st = ST_OK; old_v = '0; eff_m = '0;
    end
  end

  assign new_v      = (old_v & ~eff_m) | (reg_wdata & eff_m);
  assign reg_status = st;
  assign reg_rdata  = (st == ST_OK) ? old_v : '0;
  assign wr_ok      = reg_valid && (st == ST_OK);
  assign claim      = reg_valid && (reg_sel == SEL_TOP) && (|reg_wmask) && (top_id != '0);

  always_comb begin
    pend_n = pend;
    en_n   = en;
    if (wr_ok && in_pend) pend_n[gi*64 +: 64] = new_v;
    if (wr_ok && in_en)   en_n[gi*64 +: 64]   = new_v;
    if (claim)            pend_n[IW'(top_id)] = 1'b0;
    if (set_hit)          pend_n[IW'(set_id)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deliv <= 1'b0;
      thr   <= '0;
      pend  <= '0;
      en    <= '0;
    end else begin
      if (wr_ok && reg_sel == SEL_DELIV) deliv <= new_v[0];
      if (wr_ok && reg_sel == SEL_THR)   thr   <= new_v[ID_W-1:0];
      pend <= pend_n;
      en   <= en_n;
    end
  end

  assign eintr = deliv && (top_id != '0);
endmodule

module msi_intr_file_chk #(
  parameter int ID_W      = 11,
  parameter int NUM_IDS   = 128,
  parameter int ADDR_W    = 12,
  parameter int TOP_SHIFT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mmio_valid,
  input logic              mmio_write,
  input logic [ADDR_W-1:0] mmio_addr,
  input logic [2:0]        mmio_size,
  input logic [31:0]       mmio_wdata,
  input logic              mmio_err,
  input logic              mmio_reject,
  input logic              reg_valid,
  input logic [11:0]       reg_sel,
  input logic [63:0]       reg_rdata,
  input logic [1:0]        reg_status,
  input logic              eintr
);
  localparam logic [63:0] IDM = (64'd1 << ID_W) - 64'd1;

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mmio_valid |-> !mmio_err && !mmio_reject);
  p_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_valid && mmio_size != 3'd4 |-> mmio_err && !mmio_reject);
  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_valid && mmio_write && mmio_size == 3'd4 && mmio_addr == '0 &&
    mmio_wdata >= 32'(NUM_IDS) |-> mmio_reject);
  p_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |-> reg_rdata == '0 && reg_status == 2'd0);
  p_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_sel[11:7] == 5'b00001 && reg_sel[0] |-> reg_status == 2'd1 && reg_rdata == '0);
  p_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_sel < 12'h070 |-> reg_status == 2'd2 && reg_rdata == '0);
  p_bit0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && (reg_sel == 12'h080 || reg_sel == 12'h0C0) |-> !reg_rdata[0]);
  p_deliv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_sel == 12'h070 |-> reg_rdata[63:1] == '0);
  p_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_sel == 12'h072 |-> (reg_rdata & ~IDM) == '0);
  p_topfmt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_sel == 12'h15C |->
    reg_rdata == (((reg_rdata & IDM) << TOP_SHIFT) | (reg_rdata & IDM)));
  p_eint_top_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_sel == 12'h15C && reg_rdata == '0 |-> !eintr);
  p_eint_del_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_sel == 12'h070 && !reg_rdata[0] |-> !eintr);
endmodule

bind msi_intr_file msi_intr_file_chk #(
  .ID_W(ID_W), .NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W), .TOP_SHIFT(TOP_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mmio_valid(mmio_valid), .mmio_write(mmio_write),
  .mmio_addr(mmio_addr), .mmio_size(mmio_size), .mmio_wdata(mmio_wdata),
  .mmio_err(mmio_err), .mmio_reject(mmio_reject), .reg_valid(reg_valid),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata), .reg_status(reg_status), .eintr(eintr)
);

// File: tb/sim_msi_intr_file.sv
`timescale 1ns/1ps
module sim_msi_intr_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmio_valid = 1'b0, mmio_write = 1'b0;
  logic [11:0] mmio_addr = '0;
  logic [2:0]  mmio_size = '0;
  logic [31:0] mmio_wdata = '0;
  logic        mmio_err, mmio_reject;
  logic        reg_valid = 1'b0;
  logic [11:0] reg_sel = '0;
  logic [63:0] reg_wdata = '0, reg_wmask = '0;
  logic [63:0] reg_rdata;
  logic [1:0]  reg_status;
  logic        eintr;

  always #2.5 clk = ~clk;

  msi_intr_file u0 (
    .clk(clk), .rst_n(rst_n), .mmio_valid(mmio_valid), .mmio_write(mmio_write),
    .mmio_addr(mmio_addr), .mmio_size(mmio_size), .mmio_wdata(mmio_wdata),
    .mmio_err(mmio_err), .mmio_reject(mmio_reject), .reg_valid(reg_valid),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
    .reg_rdata(reg_rdata), .reg_status(reg_status), .eintr(eintr)
  );

  typedef struct {
    logic [63:0] rd;
    logic [1:0]  st;
    logic        err, rej, ei;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [11:0] DEL = 12'h070, THR = 12'h072, P0 = 12'h080, P2 = 12'h082;
  localparam logic [11:0] E0 = 12'h0C0, E2 = 12'h0C2, TOP = 12'h15C;
  localparam logic [63:0] ONES = '1;

  task automatic op(input bit rv, input logic [11:0] sel, input logic [63:0] wd, input logic [63:0] wm,
                    input bit mv, input bit mw, input logic [11:0] ma, input logic [2:0] ms,
                    input logic [31:0] md, input logic [63:0] e_rd, input logic [1:0] e_st,
                    input bit e_err, input bit e_rej, input bit e_ei, input string tag);
    item_t it;
    @(negedge clk);
    reg_valid = rv; reg_sel = sel; reg_wdata = wd; reg_wmask = wm;
    mmio_valid = mv; mmio_write = mw; mmio_addr = ma; mmio_size = ms; mmio_wdata = md;
    it.rd = e_rd; it.st = e_st; it.err = e_err; it.rej = e_rej; it.ei = e_ei; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #1;
    reg_valid = 1'b0; mmio_valid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] sel, input logic [63:0] e, input logic [1:0] st,
                    input bit ei, input string tag);
    op(1, sel, 0, 0, 0, 0, 0, 0, 0, e, st, 0, 0, ei, tag);
  endtask

  task automatic wr(input logic [11:0] sel, input logic [63:0] d, input logic [63:0] m,
                    input logic [63:0] e, input logic [1:0] st, input bit ei, input string tag);
    op(1, sel, d, m, 0, 0, 0, 0, 0, e, st, 0, 0, ei, tag);
  endtask

  task automatic mm(input bit w, input logic [11:0] a, input logic [2:0] s, input logic [31:0] d,
                    input bit err, input bit rej, input bit ei, input string tag);
    op(0, 0, 0, 0, 1, w, a, s, d, 0, 0, err, rej, ei, tag);
  endtask

  task automatic both(input logic [31:0] id, input logic [63:0] e, input bit ei, input string tag);
    op(1, TOP, 64'h5A5A, ONES, 1, 1, 0, 3'd4, id, e, 0, 0, 0, ei, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1.5;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (reg_rdata !== it.rd || reg_status !== it.st || mmio_err !== it.err ||
            mmio_reject !== it.rej || eintr !== it.ei) begin
          fails++;
          $display("FAIL %s: got rdata=%h st=%0d err=%b rej=%b eintr=%b, expected rdata=%h st=%0d err=%b rej=%b eintr=%b",
                   it.tag, reg_rdata, reg_status, mmio_err, mmio_reject, eintr,
                   it.rd, it.st, it.err, it.rej, it.ei);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd(DEL, 0, 0, 0, "R1");
    rd(TOP, 0, 0, 0, "R1");
    rd(P0, 0, 0, 0, "R1");
    rd(E2, 0, 0, 0, "R1");
    wr(E0, ONES, ONES, 0, 0, 0, "R8");
    rd(E0, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, "R8");
    wr(E2, ONES, 64'h0000_0000_FFFF_FFFF, 0, 0, 0, "R6");
    wr(E2, 0, 64'hF0, 64'h0000_0000_FFFF_FFFF, 0, 0, "R6");
    rd(E2, 64'h0000_0000_FFFF_FF0F, 0, 0, "R6");
    mm(1, 12'h000, 3'd4, 32'd5, 0, 0, 0, "R2");
    rd(P0, 64'h20, 0, 0, "R2");
    rd(TOP, 64'h0005_0005, 0, 0, "R10 R12");
    wr(DEL, ONES, ONES, 0, 0, 0, "R7");
    rd(DEL, 1, 0, 1, "R7 R12");
    mm(1, 12'h004, 3'd4, 32'h0300_0000, 0, 0, 1, "R3");
    rd(P0, 64'h28, 0, 1, "R3");
    rd(TOP, 64'h0003_0003, 0, 1, "R10");
    mm(1, 12'h000, 3'd4, 32'd0, 0, 0, 1, "R4");
    mm(1, 12'h000, 3'd4, 32'd128, 0, 1, 1, "R4");
    mm(1, 12'h004, 3'd4, 32'h8000_0000, 0, 1, 1, "R4");
    rd(P0, 64'h28, 0, 1, "R4");
    rd(P2, 0, 0, 1, "R4");
    mm(1, 12'h000, 3'd2, 32'd7, 1, 0, 1, "R5");
    mm(1, 12'h002, 3'd4, 32'd7, 1, 0, 1, "R5");
    mm(0, 12'h000, 3'd4, 32'd9, 0, 0, 1, "R5");
    rd(P0, 64'h28, 0, 1, "R5");
    wr(THR, 64'hFFFF, ONES, 0, 0, 1, "R7");
    rd(THR, 64'h7FF, 0, 1, "R7 R10");
    wr(THR, 3, ONES, 64'h7FF, 0, 1, "R10");
    rd(TOP, 0, 0, 0, "R10 R12");
    wr(THR, 4, ONES, 3, 0, 0, "R10");
    rd(TOP, 64'h0003_0003, 0, 1, "R10");
    wr(TOP, 0, ONES, 64'h0003_0003, 0, 1, "R11");
    rd(P0, 64'h20, 0, 0, "R11 R12");
    wr(THR, 0, ONES, 4, 0, 0, "R10");
    wr(TOP, 64'hFFFF, 0, 64'h0005_0005, 0, 1, "R11");
    rd(P0, 64'h20, 0, 1, "R11");
    rd(12'h081, 0, 1, 1, "R9");
    wr(12'h0C1, ONES, ONES, 0, 1, 1, "R9");
    rd(12'h084, 0, 1, 1, "R9");
    rd(12'h0C6, 0, 1, 1, "R9");
    rd(12'h071, 0, 2, 1, "R9");
    rd(12'h000, 0, 2, 1, "R9");
    rd(E0, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, "R9");
    wr(P0, 1, 1, 64'h20, 0, 1, "R8");
    rd(P0, 64'h20, 0, 1, "R8");
    mm(1, 12'h000, 3'd4, 32'd70, 0, 0, 1, "R10");
    wr(TOP, 64'h123, 1, 64'h0005_0005, 0, 1, "R11");
    rd(TOP, 0, 0, 0, "R10");
    rd(P2, 64'h40, 0, 0, "R10");
    mm(1, 12'h000, 3'd4, 32'd72, 0, 0, 0, "R10");
    rd(TOP, 64'h0048_0048, 0, 1, "R10");
    both(32'd72, 64'h0048_0048, 1, "R13");
    rd(P2, 64'h140, 0, 1, "R13");
    both(32'd65, 64'h0048_0048, 1, "R13");
    rd(P2, 64'h42, 0, 1, "R13");
    rd(TOP, 64'h0041_0041, 0, 1, "R13");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule